// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is the switching element of one plane of a two-dimensional mesh on-chip network. It has five ports. Four of them link to the neighbouring routers in the north, south, east and west directions, and the fifth injects and ejects local traffic. Packets are sent as flits and use wormhole flow control. The head flit carries the destination coordinates. The router steers each packet by dimension order: it first moves the packet along X until X matches, then along Y, and delivers it locally once both coordinates match.

Each input has a small queue, but a flit is written into it only when it cannot move on in the cycle it arrives. At zero load, a flit goes straight into the registered output of its chosen port, so it crosses the router in one cycle. Each output has its own round-robin arbiter. Once a head flit wins an output, that output stays locked to its packet until the tail leaves. Every link has a forward valid bit and a backward full bit. A sender whose flit is refused holds that flit unchanged on its output register.

The tile coordinates are inputs, so one netlist serves every mesh position. Flit width, queue depth and coordinate width are parameters.

Top module: `mwr_router`

## Requirements
- R1: After reset, no output port shows a valid flit and no input signals full.
- R2: A head or single flit whose destination X is larger than the local X leaves on the east port (index 3). If X is smaller, it leaves on the west port (4). When X matches, a larger Y selects north (1) and a smaller Y selects south (2). When both match, it leaves on the local port (0).
- R3: From the cycle a head flit is sent on an output, that output carries only flits of the same packet until the tail flit has been sent.
- R4: A free output grants the first requesting head at or after its pointer, counting upward in port index and wrapping after 4. The pointer starts at 0. When a tail or single flit is sent, the pointer moves to the index one above the releasing input.
- R5: An input takes a flit in every cycle in which the flit's valid is high and that input's full signal is low. Flits are never lost, and flits from one input are never reordered.
- R6: While an output shows a valid flit and its downstream full signal is high, the next cycle shows the same flit, still valid.
- R7: At zero load, a flit presented on an input in one cycle appears on its output port in the following cycle.
- R8: An input queue holds a flit only if that flit could not move in its arrival cycle. The input's full signal is high exactly when QDEPTH flits are queued, and every injected flit is eventually delivered.
- R9: The top two bits of a flit give its type: 00 body, 01 head, 10 tail, 11 single-flit packet. In a head flit, bits [2:0] hold the destination X and bits [5:3] hold the destination Y.
- R10: In any cycle, a flit from a given input is granted to at most one output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_x_i | input | COORD_W | X coordinate of this tile |
| cur_y_i | input | COORD_W | Y coordinate of this tile |
| rx_flit_i | input | 5*FLIT_W | Incoming flits, port p at bits [p*FLIT_W +: FLIT_W] |
| rx_vld_i | input | 5 | Incoming flit valid, one per port |
| rx_full_o | output | 5 | Back-pressure to each upstream sender |
| tx_flit_o | output | 5*FLIT_W | Registered outgoing flits |
| tx_vld_o | output | 5 | Outgoing flit valid, one per port |
| tx_full_i | input | 5 | Back-pressure from each downstream receiver |

## Verification
The hardest state to reach is a locked output whose owner stalls partway through a packet, while heads from other inputs wait for that same output and their queues fill until full rises. The bench gets there in two ways. In directed phases it holds a downstream full signal high and sends long packets and simultaneous heads aimed at one port. It then runs a long phase of random packet lengths, destinations and per-port stalls, comparing every cycle against a behavioural model that tracks queue contents, locks and pointers.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
   localparam int NPORT   = 5;
   localparam int IDX_W   = 3;
   localparam int P_LOCAL = 0;
   localparam int P_NORTH = 1;
   localparam int P_SOUTH = 2;
   localparam int P_EAST  = 3;
   localparam int P_WEST  = 4;
   // flit kind in the top two bits: bit 1 closes a packet, bit 0 opens one
   localparam logic [1:0] FK_BODY = 2'b00;
   localparam logic [1:0] FK_HEAD = 2'b01;
   localparam logic [1:0] FK_TAIL = 2'b10;
   localparam logic [1:0] FK_SOLO = 2'b11;
endpackage

// File: rtl/mwr_rr_arb.sv
module mwr_rr_arb #(
   parameter int N = 5,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   input  logic [IDX_W-1:0] ptr,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int k = 0; k < N; k++) begin
         if (!any && req[(int'(ptr) + k) % N]) begin
            any = 1'b1;
            idx = IDX_W'((int'(ptr) + k) % N);
         end
      end
   end
endmodule

// File: rtl/mwr_in_port.sv
module mwr_in_port
   import mwr_pkg::*;
#(
   parameter int FLIT_W  = 32,
   parameter int QDEPTH  = 4,
   parameter int COORD_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [COORD_W-1:0] cur_x,
   input  logic [COORD_W-1:0] cur_y,
   input  logic [FLIT_W-1:0]  rx_flit,
   input  logic               rx_vld,
   output logic               rx_full,
   output logic               fwd_vld,
   output logic [FLIT_W-1:0]  fwd_flit,
   output logic [NPORT-1:0]   fwd_dst,
   output logic               fwd_head,
   input  logic               fwd_take
);
   localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
   localparam int CNT_W = $clog2(QDEPTH + 1);

   logic [FLIT_W-1:0]  mem [QDEPTH];
   logic [PTR_W-1:0]   rd_q, wr_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [NPORT-1:0]   route_q;
   logic [NPORT-1:0]   xy_dst;
   logic [COORD_W-1:0] dst_x, dst_y;
   logic               q_some, rx_acc, bypass, push, pop;

   assign q_some   = (cnt_q != '0);
   assign rx_full  = (cnt_q == CNT_W'(QDEPTH));
   assign rx_acc   = rx_vld & ~rx_full;
   assign fwd_vld  = q_some | rx_vld;
   assign fwd_flit = q_some ? mem[rd_q] : rx_flit;
   assign fwd_head = fwd_flit[FLIT_W-2];
   assign dst_x    = fwd_flit[COORD_W-1:0];
   assign dst_y    = fwd_flit[2*COORD_W-1:COORD_W];

   // dimension order: X first, then Y, then eject
   always_comb begin
      xy_dst = '0;
      if (dst_x > cur_x)      xy_dst[P_EAST]  = 1'b1;
      else if (dst_x < cur_x) xy_dst[P_WEST]  = 1'b1;
      else if (dst_y > cur_y) xy_dst[P_NORTH] = 1'b1;
      else if (dst_y < cur_y) xy_dst[P_SOUTH] = 1'b1;
      else                    xy_dst[P_LOCAL] = 1'b1;
   end

   assign fwd_dst = fwd_head ? xy_dst : route_q;
   assign bypass  = fwd_take & ~q_some;
   assign pop     = fwd_take & q_some;
   assign push    = rx_acc & ~bypass;

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= rx_flit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q    <= '0;
         wr_q    <= '0;
         cnt_q   <= '0;
         route_q <= '0;
      end else begin
         if (push) wr_q <= (wr_q == PTR_W'(QDEPTH-1)) ? '0 : wr_q + 1'b1;
         if (pop)  rd_q <= (rd_q == PTR_W'(QDEPTH-1)) ? '0 : rd_q + 1'b1;
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
         if (fwd_take & fwd_head) route_q <= xy_dst;
      end
   end
endmodule

// File: rtl/mwr_out_port.sv
module mwr_out_port
   import mwr_pkg::*;
#(
   parameter int FLIT_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPORT-1:0]        req,
   input  logic [NPORT-1:0]        head,
   input  logic [NPORT*FLIT_W-1:0] flits,
   input  logic                    tx_full,
   output logic [NPORT-1:0]        gnt,
   output logic                    tx_vld,
   output logic [FLIT_W-1:0]       tx_flit
);
   logic              lock_q, vld_q;
   logic [IDX_W-1:0]  owner_q, ptr_q;
   logic [FLIT_W-1:0] flit_q;
   logic [NPORT-1:0]  arb_req;
   logic              arb_any, sel_any, can_load, move;
   logic [IDX_W-1:0]  arb_idx, sel_idx;
   logic [FLIT_W-1:0] sel_flit;

   assign arb_req = lock_q ? '0 : (req & head);

   mwr_rr_arb #(.N(NPORT)) arb_i (
      .req (arb_req),
      .ptr (ptr_q),
      .any (arb_any),
      .idx (arb_idx)
   );

   assign can_load = ~vld_q | ~tx_full;
   assign sel_idx  = lock_q ? owner_q : arb_idx;
   assign sel_any  = lock_q ? req[owner_q] : arb_any;
   assign sel_flit = flits[int'(sel_idx)*FLIT_W +: FLIT_W];
   assign move     = can_load & sel_any;

   always_comb begin
      gnt = '0;
      if (move) gnt[sel_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q  <= 1'b0;
         owner_q <= '0;
         ptr_q   <= '0;
         vld_q   <= 1'b0;
         flit_q  <= '0;
      end else begin
         if (can_load) vld_q <= sel_any;
         if (move) begin
            flit_q <= sel_flit;
            if (sel_flit[FLIT_W-1]) begin
               lock_q <= 1'b0;
               ptr_q  <= (sel_idx == IDX_W'(NPORT-1)) ? '0 : sel_idx + 1'b1;
            end else if (sel_flit[FLIT_W-2]) begin
               lock_q  <= 1'b1;
               owner_q <= sel_idx;
            end
         end
      end
   end

   assign tx_vld  = vld_q;
   assign tx_flit = flit_q;
endmodule

// File: rtl/mwr_router.sv
module mwr_router
   import mwr_pkg::*;
#(
   parameter int FLIT_W  = 32,
   parameter int QDEPTH  = 4,
   parameter int COORD_W = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [COORD_W-1:0]      cur_x_i,
   input  logic [COORD_W-1:0]      cur_y_i,
   input  logic [NPORT*FLIT_W-1:0] rx_flit_i,
   input  logic [NPORT-1:0]        rx_vld_i,
   output logic [NPORT-1:0]        rx_full_o,
   output logic [NPORT*FLIT_W-1:0] tx_flit_o,
   output logic [NPORT-1:0]        tx_vld_o,
   input  logic [NPORT-1:0]        tx_full_i
);
   generate
      if (FLIT_W < 2*COORD_W + 3) begin : g_bad_width
         initial $fatal(1, "FLIT_W too small for coordinates and kind field");
      end
      if (QDEPTH < 1) begin : g_bad_depth
         initial $fatal(1, "QDEPTH must be at least 1");
      end
      if (COORD_W < 1) begin : g_bad_coord
         initial $fatal(1, "COORD_W must be at least 1");
      end
   endgenerate

   logic [NPORT-1:0]              fwd_vld, fwd_head, take;
   logic [NPORT*FLIT_W-1:0]       fwd_flits;
   logic [NPORT-1:0][NPORT-1:0]   fwd_dst;
   logic [NPORT-1:0][NPORT-1:0]   req_m;
   logic [NPORT-1:0][NPORT-1:0]   gnt_m;

   for (genvar i = 0; i < NPORT; i++) begin : g_in
      mwr_in_port #(.FLIT_W(FLIT_W), .QDEPTH(QDEPTH), .COORD_W(COORD_W)) in_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .cur_x    (cur_x_i),
         .cur_y    (cur_y_i),
         .rx_flit  (rx_flit_i[i*FLIT_W +: FLIT_W]),
         .rx_vld   (rx_vld_i[i]),
         .rx_full  (rx_full_o[i]),
         .fwd_vld  (fwd_vld[i]),
         .fwd_flit (fwd_flits[i*FLIT_W +: FLIT_W]),
         .fwd_dst  (fwd_dst[i]),
         .fwd_head (fwd_head[i]),
         .fwd_take (take[i])
      );
   end

   always_comb begin
      for (int o = 0; o < NPORT; o++)
         for (int i = 0; i < NPORT; i++)
            req_m[o][i] = fwd_vld[i] & fwd_dst[i][o];
   end

   for (genvar o = 0; o < NPORT; o++) begin : g_out
      mwr_out_port #(.FLIT_W(FLIT_W)) out_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (req_m[o]),
         .head    (fwd_head),
         .flits   (fwd_flits),
         .tx_full (tx_full_i[o]),
         .gnt     (gnt_m[o]),
         .tx_vld  (tx_vld_o[o]),
         .tx_flit (tx_flit_o[o*FLIT_W +: FLIT_W])
      );
   end

   always_comb begin
      take = '0;
      for (int o = 0; o < NPORT; o++) take = take | gnt_m[o];
   end
endmodule

// File: rtl/mwr_router_chk.sv
module mwr_router_chk
   import mwr_pkg::*;
#(
   parameter int FLIT_W  = 32,
   parameter int COORD_W = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [COORD_W-1:0]        cur_x,
   input logic [COORD_W-1:0]        cur_y,
   input logic [NPORT-1:0]          tx_vld,
   input logic [NPORT*FLIT_W-1:0]   tx_flit,
   input logic [NPORT-1:0]          tx_full,
   input logic [NPORT-1:0][NPORT-1:0] gnt_m
);
   function automatic int exp_port(input logic [COORD_W-1:0] dx, input logic [COORD_W-1:0] dy);
      if (dx > cur_x) return P_EAST;
      if (dx < cur_x) return P_WEST;
      if (dy > cur_y) return P_NORTH;
      if (dy < cur_y) return P_SOUTH;
      return P_LOCAL;
   endfunction

   logic [NPORT-1:0] open_q;
   logic [NPORT-1:0] col [NPORT];

   always_comb begin
      for (int i = 0; i < NPORT; i++)
         for (int o = 0; o < NPORT; o++)
            col[i][o] = gnt_m[o][i];
   end

   for (genvar o = 0; o < NPORT; o++) begin : g_chk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) open_q[o] <= 1'b0;
         else if (tx_vld[o] && !tx_full[o]) begin
            if (tx_flit[o*FLIT_W + FLIT_W-1])      open_q[o] <= 1'b0;
            else if (tx_flit[o*FLIT_W + FLIT_W-2]) open_q[o] <= 1'b1;
         end
      end

      assert_hold_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_vld[o] && tx_full[o]) |=> (tx_vld[o] && $stable(tx_flit[o*FLIT_W +: FLIT_W])));

      assert_route_xy_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_vld[o] && tx_flit[o*FLIT_W + FLIT_W-2]) |->
         (exp_port(tx_flit[o*FLIT_W +: COORD_W], tx_flit[o*FLIT_W + COORD_W +: COORD_W]) == o));

      assert_body_inside_packet_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_vld[o] && !tx_flit[o*FLIT_W + FLIT_W-2]) |-> open_q[o]);

      assert_head_on_free_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_vld[o] && tx_flit[o*FLIT_W + FLIT_W-2]) |-> !open_q[o]);
   end

   for (genvar i = 0; i < NPORT; i++) begin : g_gnt
      assert_one_grant_per_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(col[i]));
   end
endmodule

bind mwr_router mwr_router_chk #(.FLIT_W(FLIT_W), .COORD_W(COORD_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .cur_x   (cur_x_i),
   .cur_y   (cur_y_i),
   .tx_vld  (tx_vld_o),
   .tx_flit (tx_flit_o),
   .tx_full (tx_full_i),
   .gnt_m   (gnt_m)
);

// File: tb/mwr_router_tb_top.sv
module mwr_router_tb_top;
   import mwr_pkg::*;
   localparam int FW  = 32;
   localparam int QD  = 4;
   localparam int CW  = 3;
   localparam int CAP = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CW-1:0] cur_x = 3'd3;
   logic [CW-1:0] cur_y = 3'd4;
   logic [NPORT*FW-1:0] rx_flit, tx_flit;
   logic [NPORT-1:0] rx_vld, rx_full, tx_vld, tx_full;
   logic [NPORT-1:0] stall_mask;

   always #4 clk = ~clk;

   mwr_router #(.FLIT_W(FW), .QDEPTH(QD), .COORD_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cur_x_i(cur_x), .cur_y_i(cur_y),
      .rx_flit_i(rx_flit), .rx_vld_i(rx_vld), .rx_full_o(rx_full),
      .tx_flit_o(tx_flit), .tx_vld_o(tx_vld), .tx_full_i(tx_full)
   );

   int checks = 0;
   int errors = 0;
   int tag = 1;
   int injected = 0;
   int delivered = 0;

   // traffic sources, one per input
   logic [FW-1:0] src_mem [NPORT][CAP];
   int src_rd [NPORT];
   int src_wr [NPORT];

   // behavioural reference state
   logic [FW-1:0] mq [NPORT][QD];
   int            mq_n [NPORT];
   int            m_rt [NPORT];
   bit            m_lock [NPORT];
   int            m_own [NPORT];
   int            m_ptr [NPORT];
   bit            m_vld [NPORT];
   logic [FW-1:0] m_flit [NPORT];

   task automatic chk(input bit ok, input string what, input logic [FW-1:0] act, input logic [FW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", what, act, exp);
      end
   endtask

   function automatic int xy_port(input logic [FW-1:0] f);
      int dx, dy;
      dx = int'(f[2:0]);
      dy = int'(f[5:3]);
      if (dx > int'(cur_x)) return 3;
      if (dx < int'(cur_x)) return 4;
      if (dy > int'(cur_y)) return 1;
      if (dy < int'(cur_y)) return 2;
      return 0;
   endfunction

   // R9: kind in [31:30], X in [2:0], Y in [5:3]
   task automatic add_pkt(input int i, input int dx, input int dy, input int len);
      for (int k = 0; k < len; k++) begin
         logic [1:0] kind;
         logic [FW-1:0] f;
         if (len == 1) kind = 2'b11;
         else if (k == 0) kind = 2'b01;
         else if (k == len-1) kind = 2'b10;
         else kind = 2'b00;
         f = {kind, tag[23:0], dy[2:0], dx[2:0]};
         tag++;
         src_mem[i][src_wr[i] % CAP] = f;
         src_wr[i]++;
         injected++;
      end
   endtask

   task automatic drive();
      for (int i = 0; i < NPORT; i++) begin
         rx_vld[i] = (src_wr[i] > src_rd[i]);
         rx_flit[i*FW +: FW] = rx_vld[i] ? src_mem[i][src_rd[i] % CAP] : '0;
      end
      tx_full = stall_mask;
   endtask

   task automatic compare();
      for (int o = 0; o < NPORT; o++) begin
         chk(tx_vld[o] === m_vld[o] && (!m_vld[o] || tx_flit[o*FW +: FW] === m_flit[o]),
             $sformatf("R2 R3 R4 R7 tx port %0d vld %0b/%0b", o, tx_vld[o], m_vld[o]),
             tx_flit[o*FW +: FW], m_flit[o]);
      end
      for (int i = 0; i < NPORT; i++) begin
         chk(rx_full[i] === (mq_n[i] == QD), $sformatf("R5 R8 rx_full port %0d", i),
             FW'(rx_full[i]), FW'(mq_n[i] == QD));
      end
   endtask

   task automatic model_advance();
      bit front_v [NPORT];
      logic [FW-1:0] front_f [NPORT];
      int dst [NPORT];
      bit hd [NPORT];
      bit acc [NPORT];
      bit taken [NPORT];
      int qn0 [NPORT];
      for (int o = 0; o < NPORT; o++)
         if (m_vld[o] && !stall_mask[o]) delivered++;
      for (int i = 0; i < NPORT; i++) begin
         bit in_v;
         in_v = (src_wr[i] > src_rd[i]);
         qn0[i] = mq_n[i];
         acc[i] = in_v && (mq_n[i] < QD);
         front_v[i] = (mq_n[i] > 0) || in_v;
         front_f[i] = (mq_n[i] > 0) ? mq[i][0] : (in_v ? src_mem[i][src_rd[i] % CAP] : '0);
         hd[i] = front_f[i][FW-2];
         dst[i] = hd[i] ? xy_port(front_f[i]) : m_rt[i];
         taken[i] = 1'b0;
      end
      for (int o = 0; o < NPORT; o++) begin
         int w;
         bit can;
         w = -1;
         can = !m_vld[o] || !stall_mask[o];
         if (m_lock[o]) begin
            if (front_v[m_own[o]] && dst[m_own[o]] == o) w = m_own[o];
         end else begin
            for (int k = 0; k < NPORT; k++) begin
               int j;
               j = (m_ptr[o] + k) % NPORT;
               if (w < 0 && front_v[j] && hd[j] && dst[j] == o) w = j;
            end
         end
         if (can) begin
            if (w >= 0) begin
               m_vld[o] = 1'b1;
               m_flit[o] = front_f[w];
               taken[w] = 1'b1;
               if (front_f[w][FW-1]) begin
                  m_lock[o] = 1'b0;
                  m_ptr[o] = (w + 1) % NPORT;
               end else if (front_f[w][FW-2]) begin
                  m_lock[o] = 1'b1;
                  m_own[o] = w;
               end
            end else begin
               m_vld[o] = 1'b0;
            end
         end
      end
      for (int i = 0; i < NPORT; i++) begin
         if (taken[i] && hd[i]) m_rt[i] = dst[i];
         if (taken[i] && qn0[i] > 0) begin
            for (int k = 0; k < QD-1; k++) mq[i][k] = mq[i][k+1];
            mq_n[i]--;
         end
         if (acc[i] && !(taken[i] && qn0[i] == 0)) begin
            mq[i][mq_n[i]] = src_mem[i][src_rd[i] % CAP];
            mq_n[i]++;
         end
         if (acc[i]) src_rd[i]++;
      end
   endtask

   task automatic step();
      @(negedge clk);
      drive();
      #1;
      compare();
      model_advance();
   endtask

   function automatic bit idle();
      for (int i = 0; i < NPORT; i++)
         if (src_wr[i] > src_rd[i] || mq_n[i] != 0 || m_vld[i]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic drain();
      stall_mask = '0;
      for (int n = 0; n < 400 && !idle(); n++) step();
      step();
   endtask

   initial begin
      for (int i = 0; i < NPORT; i++) begin
         src_rd[i] = 0; src_wr[i] = 0; mq_n[i] = 0; m_rt[i] = 0;
         m_lock[i] = 1'b0; m_own[i] = 0; m_ptr[i] = 0; m_vld[i] = 1'b0; m_flit[i] = '0;
      end
      stall_mask = '0;
      rx_vld = '0; rx_flit = '0; tx_full = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(tx_vld === 5'b0, "R1 tx_vld after reset", FW'(tx_vld), '0);
      chk(rx_full === 5'b0, "R1 rx_full after reset", FW'(rx_full), '0);
      rst_n = 1'b1;

      // R7: one-cycle crossing at zero load, local input to east
      begin
         logic [FW-1:0] f;
         add_pkt(0, 4, 4, 1);
         f = src_mem[0][(src_wr[0]-1) % CAP];
         step();
         step();
         chk(tx_vld === 5'b01000 && tx_flit[3*FW +: FW] === f, "R7 zero-load latency east",
             tx_flit[3*FW +: FW], f);
         drain();
      end

      // R2 R9: each routing direction from the local input
      begin
         int dxs [5] = '{4, 1, 3, 3, 3};
         int dys [5] = '{4, 7, 6, 0, 4};
         logic [4:0] exp [5] = '{5'b01000, 5'b10000, 5'b00010, 5'b00100, 5'b00001};
         for (int t = 0; t < 5; t++) begin
            add_pkt(0, dxs[t], dys[t], 1);
            step();
            step();
            chk(tx_vld === exp[t], $sformatf("R2 R9 route case %0d", t), FW'(tx_vld), FW'(exp[t]));
         end
         drain();
      end

      // R4: four simultaneous singles to local, pointer now at 1
      begin
         logic [FW-1:0] e [4];
         for (int i = 1; i < 5; i++) begin
            add_pkt(i, 3, 4, 1);
            e[i-1] = src_mem[i][(src_wr[i]-1) % CAP];
         end
         step();
         for (int k = 0; k < 4; k++) begin
            step();
            chk(tx_vld[0] && tx_flit[0 +: FW] === e[k], $sformatf("R4 round-robin order %0d", k),
                tx_flit[0 +: FW], e[k]);
         end
         drain();
      end

      // R3 R4: two multi-flit packets compete for local; input 1 wins, no interleave
      begin
         logic [FW-1:0] e [5];
         int s1, s3;
         s1 = src_wr[1];
         s3 = src_wr[3];
         add_pkt(1, 3, 4, 3);
         add_pkt(3, 3, 4, 2);
         e[0] = src_mem[1][s1 % CAP];
         e[1] = src_mem[1][(s1+1) % CAP];
         e[2] = src_mem[1][(s1+2) % CAP];
         e[3] = src_mem[3][s3 % CAP];
         e[4] = src_mem[3][(s3+1) % CAP];
         step();
         for (int k = 0; k < 5; k++) begin
            step();
            chk(tx_vld[0] && tx_flit[0 +: FW] === e[k], $sformatf("R3 R4 wormhole sequence %0d", k),
                tx_flit[0 +: FW], e[k]);
         end
         drain();
      end

      // R6: stalled output holds its flit
      begin
         logic [FW-1:0] f;
         add_pkt(0, 5, 2, 1);
         f = src_mem[0][(src_wr[0]-1) % CAP];
         step();
         stall_mask = 5'b01000;
         step();
         step();
         step();
         chk(tx_vld[3] && tx_flit[3*FW +: FW] === f, "R6 stalled flit held", tx_flit[3*FW +: FW], f);
         drain();
      end

      // R8: queue fills behind a stalled output and raises full
      begin
         logic [FW-1:0] h;
         stall_mask = 5'b01000;
         add_pkt(0, 6, 1, 8);
         h = src_mem[0][(src_wr[0]-8) % CAP];
         for (int n = 0; n < 8; n++) step();
         chk(rx_full[0] === 1'b1, "R8 full after QDEPTH queued", FW'(rx_full[0]), FW'(1));
         chk(tx_flit[3*FW +: FW] === h, "R6 R8 head held while queue fills", tx_flit[3*FW +: FW], h);
         drain();
      end

      // random traffic with random stalls, checked every cycle against the model
      for (int n = 0; n < 1500; n++) begin
         for (int i = 0; i < NPORT; i++) begin
            if ((src_wr[i] - src_rd[i]) < 100 && ($urandom % 6) == 0)
               add_pkt(i, int'($urandom % 8), int'($urandom % 8), 1 + int'($urandom % 5));
         end
         for (int o = 0; o < NPORT; o++) stall_mask[o] = (($urandom % 4) == 0);
         step();
      end
      drain();

      // R5 R8: every injected flit delivered
      chk(injected == delivered, "R5 R8 all flits delivered", FW'(delivered), FW'(injected));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule